// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings a flat panel's four enable lines up and down in a safe order. On power-up it turns on the logic supply first, then the signal drive, then the backlight bias, and last the panel-on line. On power-down it walks the same ladder in reverse. Only one line moves per step. After every step the block waits a fixed number of complete vertical-sync periods, so that each rail can settle before the next one moves.

A request is a one-cycle pulse on `reqValid`, and `reqOn` gives its direction. A request in the direction the panel is already in finishes at once. A request in the opposite direction that arrives mid-sequence is held, and it takes effect once the current step's wait has ended. Each half of a vsync period is guarded by a cycle timeout, so a stalled or missing vsync cannot hang the sequence. `busy` marks a running sequence, and `done` pulses when a request has been fully served.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, all four enables are low, `busy` is low and `done` is low.
- R2: A power-up request raises the enables one at a time: `railEn` goes through 0001, 0011, 0111 and 1111. Bit 0 is the supply, bit 1 the signal drive, bit 2 the bias and bit 3 the panel-on line.
- R3: A power-down request lowers them in reverse order: `railEn` goes through 0111, 0011, 0001 and 0000.
- R4: No clock edge changes more than one enable bit.
- R5: After each step, before the next step or before `done`, the block waits `VSYNC_PERIODS` (default 4) full vsync periods. A full period is vsync seen low and then seen high.
- R6: Each half of a vsync period ends after at most `TIMEOUT_CYCLES` cycles even if vsync never changes. With vsync stuck at either level, consecutive steps are therefore exactly `VSYNC_PERIODS*(TIMEOUT_CYCLES+1)` cycles apart.
- R7: An idle request for the state the panel is already in (`reqOn`=1 with all enables high, or `reqOn`=0 with all low) pulses `done` on the next cycle. The enables do not change and `busy` stays low.
- R8: An opposite-direction request during a sequence is latched. When the current step's wait ends, the sequence continues in the new direction from the current enable state.
- R9: A same-direction request during a sequence has no effect on the order or the timing of the steps.
- R10: `busy` is high from the cycle after an accepted request until the end of the sequence. `done` is a single-cycle pulse, and `busy` is already low when it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle request strobe |
| reqOn | input | 1 | Request direction: 1 = power up, 0 = power down |
| vsync | input | 1 | Vertical sync, active high |
| railEn | output | NUM_RAILS | Enables: bit0 supply, bit1 signal, bit2 bias, bit3 panel-on |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a request has been served |

## Verification
A step appears on `railEn` at the clock edge where the controller sees the closing vsync rise, or the last timeout cycle, of the final period. The first step appears at the edge that samples the request. An immediate `done` appears one edge after the request. The monitor samples one time unit after each rising edge. For paced steps it counts the vsync rises it has seen since the previous change, and for stuck-vsync runs it counts cycles. The expected gap of 4 rises or `4*(TIMEOUT_CYCLES+1)` cycles is compared at the exact sample where the change shows. The first step after a request is checked only for its value, because its phase against vsync is arbitrary.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_WAIT_LOW  = 2'd1,
    SEQ_WAIT_HIGH = 2'd2
  } seqState_t;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } railStrobe_t;

endpackage

// File: rtl/panel_seq_rails.sv
module panel_seq_rails
  import panel_seq_pkg::*;
#(
  parameter int NUM_RAILS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  railStrobe_t          strobe,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 railsFull,
  output logic                 railsEmpty
);

  localparam logic [NUM_RAILS-1:0] ALL_ON = {NUM_RAILS{1'b1}};

  logic [NUM_RAILS-1:0] railQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      railQ <= '0;
    end else if (strobe.stepUp) begin
      railQ <= {railQ[NUM_RAILS-2:0], 1'b1};
    end else if (strobe.stepDown) begin
      railQ <= {1'b0, railQ[NUM_RAILS-1:1]};
    end
  end

  assign railEn     = railQ;
  assign railsFull  = (railQ == ALL_ON);
  assign railsEmpty = (railQ == '0);

  assert_one_bit_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(railQ ^ $past(railQ)) <= 1);

  assert_ladder_shape_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((railQ + 1'b1) & railQ) == '0);

  assert_no_double_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.stepUp && strobe.stepDown));

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int VSYNC_PERIODS  = 4,
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqOn,
  input  logic        vsync,
  input  logic        railsFull,
  input  logic        railsEmpty,
  output railStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  localparam int TW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int PW = (VSYNC_PERIODS > 1) ? $clog2(VSYNC_PERIODS) : 1;
  localparam logic [TW-1:0] TIMER_LAST  = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [PW-1:0] PERIOD_LAST = PW'(VSYNC_PERIODS - 1);

  seqState_t     state, stateN;
  logic          dirUp, dirUpN;
  logic          pending, pendingN;
  logic [TW-1:0] timer, timerN;
  logic [PW-1:0] periodCnt, periodCntN;
  logic          doneQ, doneN;

  logic          timerExpired;
  logic          effUp;
  logic          reached;

  assign timerExpired = (timer == TIMER_LAST);
  assign effUp        = dirUp ^ pending;
  assign reached      = effUp ? railsFull : railsEmpty;

  always_comb begin
    stateN     = state;
    dirUpN     = dirUp;
    pendingN   = pending;
    timerN     = timer;
    periodCntN = periodCnt;
    doneN      = 1'b0;
    strobe     = '0;

    unique case (state)
      SEQ_IDLE: begin
        if (reqValid) begin
          if (reqOn ? railsFull : railsEmpty) begin
            doneN = 1'b1;
          end else begin
            dirUpN          = reqOn;
            pendingN        = 1'b0;
            strobe.stepUp   = reqOn;
            strobe.stepDown = !reqOn;
            stateN          = SEQ_WAIT_LOW;
            timerN          = '0;
            periodCntN      = '0;
          end
        end
      end

      SEQ_WAIT_LOW: begin
        if (reqValid) pendingN = (reqOn != dirUp);
        if (!vsync || timerExpired) begin
          stateN = SEQ_WAIT_HIGH;
          timerN = '0;
        end else begin
          timerN = timer + 1'b1;
        end
      end

      SEQ_WAIT_HIGH: begin
        if (reqValid) pendingN = (reqOn != dirUp);
        if (vsync || timerExpired) begin
          timerN = '0;
          if (periodCnt == PERIOD_LAST) begin
            dirUpN     = effUp;
            pendingN   = reqValid ? (reqOn != effUp) : 1'b0;
            periodCntN = '0;
            if (reached) begin
              stateN   = SEQ_IDLE;
              doneN    = 1'b1;
              pendingN = 1'b0;
            end else begin
              strobe.stepUp   = effUp;
              strobe.stepDown = !effUp;
              stateN          = SEQ_WAIT_LOW;
            end
          end else begin
            periodCntN = periodCnt + 1'b1;
            stateN     = SEQ_WAIT_LOW;
          end
        end else begin
          timerN = timer + 1'b1;
        end
      end

      default: stateN = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      dirUp     <= 1'b0;
      pending   <= 1'b0;
      timer     <= '0;
      periodCnt <= '0;
      doneQ     <= 1'b0;
    end else begin
      state     <= stateN;
      dirUp     <= dirUpN;
      pending   <= pendingN;
      timer     <= timerN;
      periodCnt <= periodCntN;
      doneQ     <= doneN;
    end
  end

  assign busy = (state != SEQ_IDLE);
  assign done = doneQ;

  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TIMER_LAST);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_pending_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> busy);

  assert_already_there_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && (reqOn ? railsFull : railsEmpty)) |=> (done && !busy));

  assert_step_on_period_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (strobe.stepUp || strobe.stepDown)) |-> (state == SEQ_WAIT_HIGH));

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import panel_seq_pkg::*;
#(
  parameter int NUM_RAILS      = 4,
  parameter int VSYNC_PERIODS  = 4,
  parameter int TIMEOUT_CYCLES = 10000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqOn,
  input  logic                 vsync,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 busy,
  output logic                 done
);

  railStrobe_t strobe;
  logic        railsFull;
  logic        railsEmpty;

  panel_seq_ctrl #(
    .VSYNC_PERIODS (VSYNC_PERIODS),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOn     (reqOn),
    .vsync     (vsync),
    .railsFull (railsFull),
    .railsEmpty(railsEmpty),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  panel_seq_rails #(
    .NUM_RAILS(NUM_RAILS)
  ) uRails (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .railEn    (railEn),
    .railsFull (railsFull),
    .railsEmpty(railsEmpty)
  );

  assert_busy_after_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (railEn != $past(railEn)) |-> busy);

endmodule

// File: tb/panel_power_seq_test.sv
module panel_power_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int TO         = 50;
  localparam int NPER       = 4;
  localparam int STUCK_GAP  = NPER * (TO + 1);

  typedef struct {
    bit       isDone;
    bit [3:0] value;
    bit       checkGap;
    string    req;
  } expItem_t;

  logic       clk = 0;
  logic       rstN = 0;
  logic       reqValid = 0;
  logic       reqOn = 0;
  logic       vsync = 0;
  logic [3:0] railEn;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;
  int vsMode = 0;
  int cycle  = 0;
  expItem_t expQ[$];

  panel_power_seq #(
    .NUM_RAILS(4), .VSYNC_PERIODS(NPER), .TIMEOUT_CYCLES(TO)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOn(reqOn),
    .vsync(vsync), .railEn(railEn), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // vsync generator: mode 0 = period 10 (3 high, 7 low), 1 = stuck low, 2 = stuck high
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (vsMode == 0) begin
        vsync = (ph < 3);
        ph = (ph + 1) % 10;
      end else begin
        vsync = (vsMode == 2);
      end
    end
  end

  // monitor / scoreboard
  initial begin
    logic [3:0] prevEn = 0;
    logic       prevVs = 0;
    int riseCnt = 0;
    int lastCyc = 0;
    expItem_t it;
    @(posedge rstN);
    forever begin
      @(posedge clk); #1;
      cycle++;
      if (vsync && !prevVs) riseCnt++;
      prevVs = vsync;
      if (railEn != prevEn || done) begin
        if (expQ.size() == 0) begin
          check(0, "R9 unexpected event", int'(railEn), int'(prevEn));
        end else begin
          it = expQ.pop_front();
          if (it.isDone) begin
            check(done == 1'b1, {it.req, " done expected"}, int'(done), 1);
            check(railEn == prevEn, {it.req, " enables steady at done"}, int'(railEn), int'(prevEn));
            check(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
          end else begin
            check(railEn == it.value, it.req, int'(railEn), int'(it.value));
            check(busy == 1'b1, "R10 busy during step", int'(busy), 1);
          end
          if (it.checkGap) begin
            if (vsMode == 0)
              check(riseCnt == NPER, "R5 vsync periods between steps", riseCnt, NPER);
            else
              check(cycle - lastCyc == STUCK_GAP, "R6 timeout gap", cycle - lastCyc, STUCK_GAP);
          end
        end
        riseCnt = 0;
        lastCyc = cycle;
      end
      prevEn = railEn;
    end
  end

  task automatic push(input bit d, input bit [3:0] v, input bit g, input string r);
    expItem_t it;
    it.isDone = d; it.value = v; it.checkGap = g; it.req = r;
    expQ.push_back(it);
  endtask

  task automatic request(input bit on);
    @(negedge clk);
    reqValid = 1; reqOn = on;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic drain;
    while (expQ.size() != 0) @(posedge clk);
    repeat (5) @(posedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(railEn == 0, "R1 enables off after reset", int'(railEn), 0);
    check(busy == 0, "R1 busy low after reset", int'(busy), 0);
    check(done == 0, "R1 done low after reset", int'(done), 0);
    @(negedge clk); rstN = 1;
    repeat (3) @(posedge clk);

    // R7: already off
    push(1, 0, 0, "R7 off when off");
    request(0);
    drain();

    // R2 with R9: power up, same-direction request mid-way
    push(0, 4'b0001, 0, "R2 step1");
    push(0, 4'b0011, 1, "R2 step2");
    push(0, 4'b0111, 1, "R2 step3");
    push(0, 4'b1111, 1, "R2 step4");
    push(1, 4'b1111, 1, "R2 done");
    request(1);
    while (railEn != 4'b0011) @(posedge clk);
    repeat (7) @(posedge clk);
    request(1);
    drain();

    // R7: already on
    push(1, 0, 0, "R7 on when on");
    request(1);
    drain();

    // R3: power down
    push(0, 4'b0111, 0, "R3 step1");
    push(0, 4'b0011, 1, "R3 step2");
    push(0, 4'b0001, 1, "R3 step3");
    push(0, 4'b0000, 1, "R3 step4");
    push(1, 4'b0000, 1, "R3 done");
    request(0);
    drain();

    // R8: reverse during power-up
    push(0, 4'b0001, 0, "R8 up1");
    push(0, 4'b0011, 1, "R8 up2");
    push(0, 4'b0001, 1, "R8 reversed down1");
    push(0, 4'b0000, 1, "R8 reversed down2");
    push(1, 4'b0000, 1, "R8 done");
    request(1);
    while (railEn != 4'b0011) @(posedge clk);
    repeat (4) @(posedge clk);
    request(0);
    drain();

    // R6: vsync stuck low, power up
    vsMode = 1;
    repeat (3) @(posedge clk);
    push(0, 4'b0001, 0, "R6 low up1");
    push(0, 4'b0011, 1, "R6 low up2");
    push(0, 4'b0111, 1, "R6 low up3");
    push(0, 4'b1111, 1, "R6 low up4");
    push(1, 4'b1111, 1, "R6 low done");
    request(1);
    drain();

    // R6: vsync stuck high, power down
    vsMode = 2;
    repeat (3) @(posedge clk);
    push(0, 4'b0111, 0, "R6 high dn1");
    push(0, 4'b0011, 1, "R6 high dn2");
    push(0, 4'b0001, 1, "R6 high dn3");
    push(0, 4'b0000, 1, "R6 high dn4");
    push(1, 4'b0000, 1, "R6 high done");
    request(0);
    drain();

    #1;
    check(railEn == 0, "R3 final all off", int'(railEn), 0);
    check(busy == 0, "R10 idle at end", int'(busy), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule